// File: doc/BRIEF.md
# Stereo Audio Serial Data Transmitter

This block puts a stereo pair of 24-bit two's complement samples onto one serial data line. Its bit clock and word-select clock come from outside the block's clock domain, either from a local clock generator or from an external master. Both are brought into the system clock domain through synchronizer chains. All timing is taken from the falling edges of the bit clock seen there, and from changes of the word-select level. A static format input chooses I2S framing or left-justified framing. In I2S framing the MSB follows the word-select change by one bit clock. In left-justified framing the MSB goes out with the change itself.

Sample pairs are offered in parallel on a valid/ready handshake. The block raises ready for one system clock at each left-channel frame boundary and takes the pair if valid is high in that cycle. If no pair is offered at that boundary, the last accepted pair is sent again and an underrun flag goes high. The block does not count bit clocks per frame. It restarts its shifter at every word-select change, so frames of 48 and of 64 bit clocks need no configuration.

Top module: `audio_ser_tx`

## Requirements
- R1: While reset is asserted and after it is released, `sdata`, `s_ready` and `underrun` are low. The stored pair is zero.
- R2: The channel is decoded from the word-select level. With `fmt_lj`=0 (I2S), level 0 is left and level 1 is right. With `fmt_lj`=1 (left-justified), level 1 is left and level 0 is right.
- R3: With `fmt_lj`=1, bit 23 of the channel word goes out on the first bit-clock falling edge at which the new word-select level is seen (slot 0). Bit k goes out in slot 23-k.
- R4: With `fmt_lj`=0, slot 0 of a half-frame carries the bit held over from the previous half-frame. Bit k of the new word goes out in slot 24-k.
- R5: After its 24 data bits, a half-frame carries zeros. When an I2S half-frame is 24 slots long, bit 0 of its word goes out in slot 0 of the next half-frame.
- R6: `sdata` changes only in the system cycle after a bit-clock falling edge is detected. It never changes while the bit clock is high.
- R7: `s_ready` is high for exactly one system cycle at each left-channel boundary and at no other time. A pair is taken when `s_valid` and `s_ready` are both high.
- R8: At a left boundary without `s_valid`, the previous pair is sent again and `underrun` goes high. `underrun` holds its value until the next left boundary and clears at a left boundary with `s_valid` high.
- R9: Frames of 48 and of 64 bit clocks per word-select period are both sent correctly, with no setting.
- R10: The first falling bit-clock edge after reset only records the word-select level. No boundary is taken on it, and the line stays low until the first word-select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| sclk_in | input | 1 | Bit clock, asynchronous to clk |
| lrck_in | input | 1 | Word-select clock, asynchronous to clk |
| fmt_lj | input | 1 | Static format: 0 = I2S, 1 = left-justified |
| s_valid | input | 1 | A sample pair is offered |
| s_left | input | 24 | Left sample, two's complement |
| s_right | input | 24 | Right sample, two's complement |
| s_ready | output | 1 | One-cycle pulse at each left boundary; the pair is taken when `s_valid` is high |
| sdata | output | 1 | Serial data line, changing after bit-clock falling edges |
| underrun | output | 1 | High after a left boundary found no valid pair |

## Verification
The bench builds the block with its defaults: a 24-bit word and a two-stage synchronizer. The bit clock runs with six system clocks per phase, which leaves the three-cycle path from a bit-clock fall to the output well inside the low phase. These values bring into reach both framing formats at 48 and 64 bit clocks per frame. They also cover the I2S case where bit 0 spills into the next half-frame, the first word-select level after reset, and underrun followed by recovery.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;

  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;

  // Channel carried by a word-select level under the selected framing.
  function automatic chan_e chan_of(input logic lj, input logic ws_lvl);
    if (lj) return ws_lvl ? CH_LEFT : CH_RIGHT;
    else    return ws_lvl ? CH_RIGHT : CH_LEFT;
  endfunction

  // Line bit for a framing: left-justified drives the undelayed stream,
  // I2S drives the stream delayed by one slot.
  function automatic logic line_bit(input logic lj, input logic now_bit,
                                    input logic late_bit);
    return lj ? now_bit : late_bit;
  endfunction

endpackage

// File: rtl/audio_edge_sync.sv
module audio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/audio_frame_track.sv
module audio_frame_track
  import audio_ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fmt_lj,
  input  logic sclk_lvl,
  input  logic ws_lvl,
  output logic tick,
  output logic bnd,
  output logic bnd_left
);
  logic sclk_prev;
  logic ws_prev;
  logic armed;

  assign tick     = sclk_prev & ~sclk_lvl;
  assign bnd      = tick & armed & (ws_lvl != ws_prev);
  assign bnd_left = bnd & (chan_of(fmt_lj, ws_lvl) == CH_LEFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_prev <= 1'b0;
      ws_prev   <= 1'b0;
      armed     <= 1'b0;
    end else begin
      sclk_prev <= sclk_lvl;
      if (tick) begin
        ws_prev <= ws_lvl;
        armed   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_word_shift.sv
module audio_word_shift
  import audio_ser_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fmt_lj,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         sdata
);
  logic [W-1:0] sh;
  logic         now_q;
  logic         late_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      now_q  <= 1'b0;
      late_q <= 1'b0;
    end else if (tick) begin
      late_q <= now_q;
      if (load) begin
        now_q <= word[W-1];
        sh    <= {word[W-2:0], 1'b0};
      end else begin
        now_q <= sh[W-1];
        sh    <= {sh[W-2:0], 1'b0};
      end
    end
  end

  assign sdata = line_bit(fmt_lj, now_q, late_q);
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_in,
  input  logic              lrck_in,
  input  logic              fmt_lj,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_left,
  input  logic [WORD_W-1:0] s_right,
  output logic              s_ready,
  output logic              sdata,
  output logic              underrun
);
  localparam int N_SYNC = 2;

  logic [N_SYNC-1:0] raw_in;
  logic [N_SYNC-1:0] lvl;
  logic              sclk_fall_w;
  logic              bnd_w;
  logic              bnd_left_w;
  logic              lrck_lvl_w;
  logic [WORD_W-1:0] pair_l, pair_r;
  logic [WORD_W-1:0] load_word;

  assign raw_in = {lrck_in, sclk_in};

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    audio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(raw_in[g]), .level(lvl[g])
    );
  end

  assign lrck_lvl_w = lvl[1];

  audio_frame_track u_track (
    .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj),
    .sclk_lvl(lvl[0]), .ws_lvl(lrck_lvl_w),
    .tick(sclk_fall_w), .bnd(bnd_w), .bnd_left(bnd_left_w)
  );

  assign s_ready = bnd_left_w;

  always_comb begin
    if (bnd_left_w) load_word = s_valid ? s_left : pair_l;
    else            load_word = pair_r;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_l   <= '0;
      pair_r   <= '0;
      underrun <= 1'b0;
    end else if (bnd_left_w) begin
      underrun <= ~s_valid;
      if (s_valid) begin
        pair_l <= s_left;
        pair_r <= s_right;
      end
    end
  end

  audio_word_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .tick(sclk_fall_w),
    .load(bnd_w), .word(load_word), .sdata(sdata)
  );
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fmt_lj,
  input logic         s_valid,
  input logic [W-1:0] s_left,
  input logic         s_ready,
  input logic         sdata,
  input logic         underrun,
  input logic         sclk_fall_w,
  input logic         lrck_lvl_w
);
  p_out_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sdata) && $stable(fmt_lj)) |-> $past(sclk_fall_w));

  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  p_ready_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (fmt_lj ? lrck_lvl_w : !lrck_lvl_w));

  p_underrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> underrun);

  p_underrun_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid) |=> !underrun);

  p_underrun_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |=> $stable(underrun));

  p_lj_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid && fmt_lj) |=> (sdata == $past(s_left[W-1])));
endmodule

bind audio_ser_tx audio_ser_tx_chk #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_lj(fmt_lj), .s_valid(s_valid),
  .s_left(s_left), .s_ready(s_ready), .sdata(sdata), .underrun(underrun),
  .sclk_fall_w(sclk_fall_w), .lrck_lvl_w(lrck_lvl_w)
);

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b1, lrck_in = 1'b1, fmt_lj = 1'b0, s_valid = 1'b0;
  logic [23:0] s_left = '0, s_right = '0;
  logic s_ready, sdata, underrun;

  int n_tests = 0, n_fail = 0, n_xfer = 0;
  logic carry;
  logic [23:0] cur_l, cur_r;
  bit done = 0;

  always #4 clk = ~clk;

  audio_ser_tx u_audio_ser_tx (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .lrck_in(lrck_in),
    .fmt_lj(fmt_lj), .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
    .s_ready(s_ready), .sdata(sdata), .underrun(underrun)
  );

  always @(negedge clk) if (rst_n && s_valid && s_ready) n_xfer++;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                     input string req);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Expected slot contents (bit s = slot s) from R3, R4, R5.
  function automatic logic [31:0] exp_half(input logic lj, input int n,
                                           input logic [23:0] w, input logic c);
    logic [31:0] e = '0;
    for (int s = 0; s < n; s++) begin
      if (lj) e[s] = (s < 24) ? w[23-s] : 1'b0;
      else if (s == 0) e[s] = c;
      else e[s] = (s <= 24) ? w[24-s] : 1'b0;
    end
    return e;
  endfunction

  task automatic run_half(input logic lvl, input int n, output logic [31:0] got);
    got = '0;
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      sclk_in = 1'b0;
      lrck_in = lvl;
      repeat (HALF) @(negedge clk);
      got[s] = sdata;
      sclk_in = 1'b1;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic do_reset(input logic lj);
    logic [31:0] g;
    rst_n = 1'b0; fmt_lj = lj; s_valid = 1'b0;
    sclk_in = 1'b1; lrck_in = lj ? 1'b0 : 1'b1;
    repeat (5) @(negedge clk);
    chk({29'd0, sdata, s_ready, underrun}, 32'd0, "R1 outputs in reset");
    rst_n = 1'b1;
    carry = 1'b0; cur_l = '0; cur_r = '0;
    run_half(lj ? 1'b0 : 1'b1, 3, g);
    chk(g, 32'd0, "R10 idle before first word-select change");
  endtask

  task automatic run_frame(input logic lj, input int n, input logic v,
                           input logic [23:0] l, input logic [23:0] r,
                           input string req);
    logic [31:0] gl, gr, el, er;
    s_valid = v; s_left = l; s_right = r;
    if (v) begin cur_l = l; cur_r = r; end
    el = exp_half(lj, n, cur_l, carry);
    carry = (n == 24) ? cur_l[0] : 1'b0;
    er = exp_half(lj, n, cur_r, carry);
    run_half(lj ? 1'b1 : 1'b0, n, gl);
    s_valid = 1'b0;
    run_half(lj ? 1'b0 : 1'b1, n, gr);
    carry = (n == 24) ? cur_r[0] : 1'b0;
    chk(gl, el, {req, " left half"});
    chk(gr, er, {req, " right half"});
  endtask

  task automatic t_i2s64;
    do_reset(1'b0);
    run_frame(1'b0, 32, 1'b1, 24'hA5C3F1, 24'h123456, "R4 R2 I2S 64");
    run_frame(1'b0, 32, 1'b1, 24'h800001, 24'h7FFFFE, "R4 R5 I2S 64");
  endtask

  task automatic t_i2s48;
    do_reset(1'b0);
    run_frame(1'b0, 24, 1'b1, 24'hC00001, 24'h000001, "R5 R9 I2S 48 spill");
    run_frame(1'b0, 24, 1'b1, 24'h5A5A5B, 24'hFFFFFF, "R5 R9 I2S 48 spill");
  endtask

  task automatic t_lj;
    do_reset(1'b1);
    run_frame(1'b1, 32, 1'b1, 24'hF0F0F0, 24'h0F0F0F, "R3 R2 LJ 64");
    run_frame(1'b1, 24, 1'b1, 24'h800000, 24'h000001, "R3 R9 LJ 48");
    run_frame(1'b1, 24, 1'b1, 24'h6B1D29, 24'hD4E2C7, "R3 R9 LJ 48");
  endtask

  task automatic t_underrun;
    int x0;
    do_reset(1'b0);
    x0 = n_xfer;
    run_frame(1'b0, 32, 1'b1, 24'h13579B, 24'h2468AC, "R7 load");
    chk({31'd0, underrun}, 32'd0, "R8 no underrun with valid");
    run_frame(1'b0, 32, 1'b0, 24'hFFFFFF, 24'hFFFFFF, "R8 repeat pair");
    chk({31'd0, underrun}, 32'd1, "R8 underrun set");
    run_frame(1'b0, 32, 1'b1, 24'h00FF00, 24'hFF00FF, "R8 recover");
    chk({31'd0, underrun}, 32'd0, "R8 underrun cleared");
    chk(n_xfer - x0, 2, "R7 one transfer per valid frame");
  endtask

  initial begin
    t_i2s64();
    t_i2s48();
    t_lj();
    t_underrun();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule